// File: doc/BRIEF.md
# Variable Block Size SAD Generator

This block compares one 16x16 current macroblock against one 16x16 reference candidate and reports the sum of absolute differences (SAD) for every partition that variable block size motion estimation considers. That is 41 values across seven shapes. The first pipeline stage forms per-pixel absolute differences. A compact adder tree then folds each 4x4 tile into one of sixteen base SADs. A merge network adds only those base SADs, never raw pixels, to produce the 8x4, 4x8, 8x8, 16x8, 8x16 and 16x16 results.

A search engine drives one candidate pair per clock on flat pixel buses, with a valid flag. All 41 results come out together, with their own valid flag, a fixed four cycles later. Pixel (row r, column c) occupies byte lane r*16+c of each pixel bus. Candidate selection and window buffering are done outside the block.

Top module: `vbs_sad_gen`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by exactly 4 clock cycles. While `rst_ni` is low, and for 4 cycles after it rises, `valid_o` is 0. Asserting reset clears any results in flight.
- R2: `sad4x4_o` lane k (12 bits at bit k*12) holds the sum of |cur-ref| over rows 4*(k/4) to 4*(k/4)+3 and columns 4*(k%4) to 4*(k%4)+3. This is raster order of the tiles.
- R3: The absolute difference is correct whichever operand is larger, and identical blocks give 0. The extremes (all 255 against all 0) give 4080 per 4x4 without overflow.
- R4: `sad8x4_o` lane i (13 bits) covers 4 rows by 8 columns, with top row 4*(i/2) and left column 8*(i%2).
- R5: `sad4x8_o` lane i (13 bits) covers 8 rows by 4 columns, with top row 8*(i/4) and left column 4*(i%4).
- R6: `sad8x8_o` lane i (14 bits) covers the 8x8 quadrant with top row 8*(i/2) and left column 8*(i%2).
- R7: `sad16x8_o` lane i (15 bits) covers rows 8*i to 8*i+7 across all 16 columns. `sad8x16_o` lane i (15 bits) covers columns 8*i to 8*i+7 across all 16 rows.
- R8: `sad16x16_o` (16 bits) covers the whole macroblock and reaches 65280 at the extremes without overflow.
- R9: A new pair is accepted on every cycle. Back-to-back pairs give independent results, and pairs driven with `valid_i` low do not disturb the results of neighbouring valid pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the valid pipeline |
| valid_i | input | 1 | Candidate pair present this cycle |
| cur_i | input | 2048 | Current block pixels, byte lane r*16+c |
| ref_i | input | 2048 | Reference candidate pixels, byte lane r*16+c |
| valid_o | output | 1 | Result set present this cycle |
| sad4x4_o | output | 192 | Sixteen 12-bit 4x4 SADs |
| sad8x4_o | output | 104 | Eight 13-bit 8-wide by 4-tall SADs |
| sad4x8_o | output | 104 | Eight 13-bit 4-wide by 8-tall SADs |
| sad8x8_o | output | 56 | Four 14-bit 8x8 SADs |
| sad16x8_o | output | 30 | Two 15-bit 16-wide by 8-tall SADs |
| sad8x16_o | output | 30 | Two 15-bit 8-wide by 16-tall SADs |
| sad16x16_o | output | 16 | One 16-bit 16x16 SAD |

## Verification
A merge term that is mis-routed or truncated shows up on the first valid result after the faulty pair, four cycles after input. Either two partition families that cover the same area no longer add up to the same total, or one lane disagrees with a sum taken directly over its pixel rectangle. A patterned stimulus raises a single 4x4 tile, so an indexing fault lands in exactly one wrong lane of every shape. A skewed valid shift register shows up as a valid flag one cycle early or late against the input history.

// File: rtl/vbs_sad_pkg.sv
package vbs_sad_pkg;
  localparam int unsigned MB    = 16;            // macroblock edge
  localparam int unsigned SB    = 4;             // base tile edge
  localparam int unsigned GRID  = MB / SB;       // tiles per row
  localparam int unsigned NPIX  = MB * MB;
  localparam int unsigned NSUB  = GRID * GRID;
  localparam int unsigned TPIX  = SB * SB;
  localparam int unsigned N_HALF = NSUB / 2;     // 8x4 and 4x8 counts
  localparam int unsigned N_QUAD = 4;
  localparam int unsigned LAT   = 4;             // absdiff, tree, merge a, merge b
endpackage

// File: rtl/vbs_absdiff.sv
module vbs_absdiff #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned NPIX  = 256
) (
  input  logic                    clk_i,
  input  logic [NPIX*PIX_W-1:0]   a_i,
  input  logic [NPIX*PIX_W-1:0]   b_i,
  output logic [NPIX*PIX_W-1:0]   ad_o
);
  for (genvar g = 0; g < NPIX; g++) begin : g_pix
    logic signed [PIX_W:0] dif;
    logic        [PIX_W:0] mag;
    logic        [PIX_W-1:0] q;
    assign dif = $signed({1'b0, a_i[g*PIX_W +: PIX_W]}) - $signed({1'b0, b_i[g*PIX_W +: PIX_W]});
    assign mag = dif[PIX_W] ? -dif : dif;
    always_ff @(posedge clk_i) q <= mag[PIX_W-1:0];
    assign ad_o[g*PIX_W +: PIX_W] = q;
  end
endmodule

// File: rtl/vbs_sad4_tree.sv
module vbs_sad4_tree #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned N     = 16,
  localparam int unsigned OW   = PIX_W + $clog2(N)
) (
  input  logic [N*PIX_W-1:0] ad_i,
  output logic [OW-1:0]      sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) sum_o = sum_o + OW'(ad_i[i*PIX_W +: PIX_W]);
  end
endmodule

// File: rtl/vbs_sad_merge.sv
module vbs_sad_merge import vbs_sad_pkg::*; #(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned W4  = PIX_W + 4,
  localparam int unsigned W84 = W4 + 1,
  localparam int unsigned W8  = W4 + 2,
  localparam int unsigned WH  = W4 + 3,
  localparam int unsigned W16 = W4 + 4
) (
  input  logic                   clk_i,
  input  logic [NSUB*W4-1:0]     s4_i,
  output logic [NSUB*W4-1:0]     s4_o,
  output logic [N_HALF*W84-1:0]  s84_o,
  output logic [N_HALF*W84-1:0]  s48_o,
  output logic [N_QUAD*W8-1:0]   s88_o,
  output logic [2*WH-1:0]        s168_o,
  output logic [2*WH-1:0]        s816_o,
  output logic [W16-1:0]         s16_o
);
  logic [W4-1:0]  s4  [NSUB];
  logic [W4-1:0]  d4  [NSUB];
  logic [W84-1:0] a84 [N_HALF];
  logic [W84-1:0] a48 [N_HALF];
  logic [W8-1:0]  a88 [N_QUAD];

  always_comb
    for (int k = 0; k < NSUB; k++) s4[k] = s4_i[k*W4 +: W4];

  // stage a: pairs and quads of base tiles
  always_ff @(posedge clk_i) begin
    for (int k = 0; k < NSUB; k++) d4[k] <= s4[k];
    for (int by = 0; by < 4; by++)
      for (int p = 0; p < 2; p++)
        a84[by*2+p] <= W84'(s4[by*4+2*p]) + W84'(s4[by*4+2*p+1]);
    for (int py = 0; py < 2; py++)
      for (int bx = 0; bx < 4; bx++)
        a48[py*4+bx] <= W84'(s4[8*py+bx]) + W84'(s4[8*py+4+bx]);
    for (int qy = 0; qy < 2; qy++)
      for (int qx = 0; qx < 2; qx++)
        a88[qy*2+qx] <= W8'(s4[8*qy+2*qx]) + W8'(s4[8*qy+2*qx+1])
                      + W8'(s4[8*qy+2*qx+4]) + W8'(s4[8*qy+2*qx+5]);
  end

  // stage b: halves and whole from quadrants
  always_ff @(posedge clk_i) begin
    for (int k = 0; k < NSUB; k++) s4_o[k*W4 +: W4] <= d4[k];
    for (int i = 0; i < N_HALF; i++) begin
      s84_o[i*W84 +: W84] <= a84[i];
      s48_o[i*W84 +: W84] <= a48[i];
    end
    for (int q = 0; q < N_QUAD; q++) s88_o[q*W8 +: W8] <= a88[q];
    for (int h = 0; h < 2; h++) begin
      s168_o[h*WH +: WH] <= WH'(a88[2*h]) + WH'(a88[2*h+1]);
      s816_o[h*WH +: WH] <= WH'(a88[h]) + WH'(a88[h+2]);
    end
    s16_o <= W16'(a88[0]) + W16'(a88[1]) + W16'(a88[2]) + W16'(a88[3]);
  end
endmodule

// File: rtl/vbs_sad_gen.sv
module vbs_sad_gen import vbs_sad_pkg::*; #(
  parameter int unsigned PIX_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [NPIX*PIX_W-1:0]         cur_i,
  input  logic [NPIX*PIX_W-1:0]         ref_i,
  output logic                          valid_o,
  output logic [NSUB*(PIX_W+4)-1:0]     sad4x4_o,
  output logic [N_HALF*(PIX_W+5)-1:0]   sad8x4_o,
  output logic [N_HALF*(PIX_W+5)-1:0]   sad4x8_o,
  output logic [N_QUAD*(PIX_W+6)-1:0]   sad8x8_o,
  output logic [2*(PIX_W+7)-1:0]        sad16x8_o,
  output logic [2*(PIX_W+7)-1:0]        sad8x16_o,
  output logic [PIX_W+8-1:0]            sad16x16_o
);
  localparam int unsigned W4 = PIX_W + 4;

  logic [LAT-1:0] vld_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], valid_i};
  assign valid_o = vld_q[LAT-1];

  logic [NPIX*PIX_W-1:0] ad;
  vbs_absdiff #(.PIX_W(PIX_W), .NPIX(NPIX)) i_absdiff (
    .clk_i (clk_i),
    .a_i   (cur_i),
    .b_i   (ref_i),
    .ad_o  (ad)
  );

  logic [NSUB*W4-1:0] s4_q;
  for (genvar k = 0; k < NSUB; k++) begin : g_tile
    localparam int unsigned R0 = SB * (k / GRID);
    localparam int unsigned C0 = SB * (k % GRID);
    logic [TPIX*PIX_W-1:0] tile_ad;
    logic [W4-1:0]         tile_sum;
    logic [W4-1:0]         tile_q;
    for (genvar i = 0; i < SB; i++) begin : g_r
      for (genvar j = 0; j < SB; j++) begin : g_c
        assign tile_ad[(i*SB+j)*PIX_W +: PIX_W] = ad[((R0+i)*MB + C0 + j)*PIX_W +: PIX_W];
      end
    end
    vbs_sad4_tree #(.PIX_W(PIX_W), .N(TPIX)) i_tree (
      .ad_i  (tile_ad),
      .sum_o (tile_sum)
    );
    always_ff @(posedge clk_i) tile_q <= tile_sum;
    assign s4_q[k*W4 +: W4] = tile_q;
  end

  vbs_sad_merge #(.PIX_W(PIX_W)) i_merge (
    .clk_i  (clk_i),
    .s4_i   (s4_q),
    .s4_o   (sad4x4_o),
    .s84_o  (sad8x4_o),
    .s48_o  (sad4x8_o),
    .s88_o  (sad8x8_o),
    .s168_o (sad16x8_o),
    .s816_o (sad8x16_o),
    .s16_o  (sad16x16_o)
  );
endmodule

// File: rtl/vbs_sad_chk.sv
module vbs_sad_chk import vbs_sad_pkg::*; #(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned W4  = PIX_W + 4,
  localparam int unsigned W84 = W4 + 1,
  localparam int unsigned W8  = W4 + 2,
  localparam int unsigned WH  = W4 + 3,
  localparam int unsigned W16 = W4 + 4,
  localparam int unsigned CW  = $clog2(LAT + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic                  valid_o,
  input logic [NSUB*W4-1:0]    sad4x4_o,
  input logic [N_HALF*W84-1:0] sad8x4_o,
  input logic [N_HALF*W84-1:0] sad4x8_o,
  input logic [N_QUAD*W8-1:0]  sad8x8_o,
  input logic [2*WH-1:0]       sad16x8_o,
  input logic [2*WH-1:0]       sad8x16_o,
  input logic [W16-1:0]        sad16x16_o
);
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 since_rst <= '0;
    else if (since_rst != CW'(LAT)) since_rst <= since_rst + 1'b1;

  logic [W16+1:0] quad_tot, row_tot, col_tot;
  always_comb begin
    quad_tot = '0;
    for (int q = 0; q < N_QUAD; q++) quad_tot = quad_tot + (W16+2)'(sad8x8_o[q*W8 +: W8]);
    row_tot = (W16+2)'(sad16x8_o[0 +: WH]) + (W16+2)'(sad16x8_o[WH +: WH]);
    col_tot = (W16+2)'(sad8x16_o[0 +: WH]) + (W16+2)'(sad8x16_o[WH +: WH]);
  end

  p_valid_delay_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == CW'(LAT)) |-> (valid_o == $past(valid_i, 4)));

  p_quiet_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != CW'(LAT)) |-> !valid_o);

  p_whole_from_quads_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (quad_tot == (W16+2)'(sad16x16_o)));

  p_halves_agree_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (row_tot == col_tot && row_tot == (W16+2)'(sad16x16_o)));

  for (genvar q = 0; q < N_QUAD; q++) begin : g_q
    localparam int unsigned QY = q / 2;
    localparam int unsigned QX = q % 2;
    p_quad_split_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (W8'(sad8x8_o[q*W8 +: W8]) ==
                   W8'(sad8x4_o[(2*QY*2+QX)*W84 +: W84]) + W8'(sad8x4_o[((2*QY+1)*2+QX)*W84 +: W84])));
    p_quad_cols_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (W8'(sad8x8_o[q*W8 +: W8]) ==
                   W8'(sad4x8_o[(QY*4+2*QX)*W84 +: W84]) + W8'(sad4x8_o[(QY*4+2*QX+1)*W84 +: W84])));
  end

  for (genvar k = 0; k < NSUB; k++) begin : g_t
    p_tile_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (32'(sad4x4_o[k*W4 +: W4]) <= 32'(TPIX) * ((32'd1 << PIX_W) - 32'd1)));
  end
endmodule

bind vbs_sad_gen vbs_sad_chk #(.PIX_W(PIX_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .valid_o    (valid_o),
  .sad4x4_o   (sad4x4_o),
  .sad8x4_o   (sad8x4_o),
  .sad4x8_o   (sad4x8_o),
  .sad8x8_o   (sad8x8_o),
  .sad16x8_o  (sad16x8_o),
  .sad8x16_o  (sad8x16_o),
  .sad16x16_o (sad16x16_o)
);

// File: tb/test_vbs_sad_gen.sv
`timescale 1ns/1ps
module test_vbs_sad_gen;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [2047:0] cur_i = '0;
  logic [2047:0] ref_i = '0;
  logic          valid_o;
  logic [191:0]  sad4x4_o;
  logic [103:0]  sad8x4_o;
  logic [103:0]  sad4x8_o;
  logic [55:0]   sad8x8_o;
  logic [29:0]   sad16x8_o;
  logic [29:0]   sad8x16_o;
  logic [15:0]   sad16x16_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit hist [4];
  int seed_q [$];
  int n_in = 0;
  int n_out = 0;

  always #5 clk_i = ~clk_i;

  vbs_sad_gen i_vbs_sad_gen (
    .clk_i, .rst_ni, .valid_i, .cur_i, .ref_i, .valid_o,
    .sad4x4_o, .sad8x4_o, .sad4x8_o, .sad8x8_o,
    .sad16x8_o, .sad8x16_o, .sad16x16_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int hsh(int s, int r, int c);
    return ((r*131 + c*71 + s*29 + r*c*7) ^ (s*13)) & 255;
  endfunction

  // mode 0: cur max/ref min, 1: reversed, 2: identical, 4: one raised tile, else random
  function automatic int pix(int s, bit is_ref, int r, int c);
    int k, base;
    case (s % 6)
      0: return is_ref ? 0 : 255;
      1: return is_ref ? 255 : 0;
      2: return hsh(s, r, c);
      4: begin
        k = (s / 6) % 16;
        base = hsh(s, r, c) & 127;
        if (!is_ref && (r / 4) * 4 + (c / 4) == k) return base + 100;
        return base;
      end
      default: return is_ref ? hsh(s + 1000, r, c) : hsh(s, r, c);
    endcase
  endfunction

  function automatic int region(int s, int r0, int c0, int h, int w);
    int acc = 0, d;
    for (int r = r0; r < r0 + h; r++)
      for (int c = c0; c < c0 + w; c++) begin
        d = pix(s, 1'b0, r, c) - pix(s, 1'b1, r, c);
        acc += (d < 0) ? -d : d;
      end
    return acc;
  endfunction

  task automatic check_set(input int s);
    int e, a;
    for (int k = 0; k < 16; k++) begin
      e = region(s, 4*(k/4), 4*(k%4), 4, 4); a = int'(sad4x4_o[k*12 +: 12]);
      chk(a == e, "R2 sad4x4", a, e);
    end
    for (int i = 0; i < 8; i++) begin
      e = region(s, 4*(i/2), 8*(i%2), 4, 8); a = int'(sad8x4_o[i*13 +: 13]);
      chk(a == e, "R4 sad8x4", a, e);
      e = region(s, 8*(i/4), 4*(i%4), 8, 4); a = int'(sad4x8_o[i*13 +: 13]);
      chk(a == e, "R5 sad4x8", a, e);
    end
    for (int q = 0; q < 4; q++) begin
      e = region(s, 8*(q/2), 8*(q%2), 8, 8); a = int'(sad8x8_o[q*14 +: 14]);
      chk(a == e, "R6 sad8x8", a, e);
    end
    for (int h = 0; h < 2; h++) begin
      e = region(s, 8*h, 0, 8, 16); a = int'(sad16x8_o[h*15 +: 15]);
      chk(a == e, "R7 sad16x8", a, e);
      e = region(s, 0, 8*h, 16, 8); a = int'(sad8x16_o[h*15 +: 15]);
      chk(a == e, "R7 sad8x16", a, e);
    end
    e = region(s, 0, 0, 16, 16); a = int'(sad16x16_o);
    chk(a == e, "R8 sad16x16", a, e);
    // R3: extremes and identical blocks
    if (s % 6 == 0 || s % 6 == 1) begin
      chk(a == 65280, "R3 extreme whole", a, 65280);
      chk(int'(sad4x4_o[0 +: 12]) == 4080, "R3 extreme tile", int'(sad4x4_o[0 +: 12]), 4080);
    end
    if (s % 6 == 2) chk(a == 0, "R3 identical", a, 0);
  endtask

  task automatic drive(input bit v, input int s);
    valid_i = v;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        cur_i[(r*16+c)*8 +: 8] = 8'(pix(s, 1'b0, r, c));
        ref_i[(r*16+c)*8 +: 8] = 8'(pix(s, 1'b1, r, c));
      end
  endtask

  // one negedge: sample against history, then drive the next pair
  task automatic step(input bit v, input int s);
    int sd;
    @(negedge clk_i);
    chk(valid_o == hist[3], "R1 valid latency", int'(valid_o), int'(hist[3]));
    if (valid_o && hist[3]) begin
      sd = seed_q.pop_front();
      n_out++;
      check_set(sd);
    end
    drive(v, s);
    for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
    if (v) begin seed_q.push_back(s); n_in++; end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 4; i++) hist[i] = 1'b0;
    seed_q.delete();
  endtask

  initial begin
    clear_hist();
    drive(1'b1, 7);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R1 reset state", int'(valid_o), 0);
    end
    rst_ni = 1'b1;
    drive(1'b0, 0);
    // R9: back-to-back valid pairs covering all modes and all raised-tile indexes
    for (int t = 0; t < 100; t++) step(1'b1, t);
    // gapped traffic, invalid slots carry unrelated data
    for (int t = 100; t < 160; t++) step((t % 3) != 1, t);
    for (int t = 0; t < 6; t++) step(1'b0, 500 + t);
    chk(n_in == n_out, "R9 all valid pairs returned", n_out, n_in);
    // R1: reset with results in flight
    step(1'b1, 3); step(1'b1, 5);
    @(negedge clk_i);
    rst_ni = 1'b0;
    drive(1'b0, 0);
    clear_hist();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R1 flush on reset", int'(valid_o), 0);
    end
    rst_ni = 1'b1;
    for (int t = 0; t < 8; t++) step(t < 2, 200 + t);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule